// File: doc/BRIEF.md
# Snapshot-Buffered Time Register Window

This block connects a byte-wide serial register port to a free-running time-of-day counter that sits outside it. The protocol engine supplies one-cycle strobes for bus start, bus stop, pointer load, byte read and byte write. The block keeps a 5-bit register pointer that covers 32 addresses. After each data byte, read or written, the pointer steps forward and wraps from 1Fh back to 00h.

The seven time and date bytes are never read straight from the counter. They are read from a snapshot copy. The snapshot is refreshed from the live counter at a bus start, at a bus stop, and when the pointer wraps to 00h. A multi-byte read therefore returns one coherent instant while the counter keeps running. A write to a time byte does not go through the snapshot. It is forwarded to the counter as a one-cycle load with the byte's index and data. Addresses 10h to 1Fh are sixteen bytes of general storage. Addresses 07h to 0Fh are unused.

Top module: `rtc_snap_window`

## Requirements
- R1: After `rst_ni` is released, the pointer is 00h, every snapshot byte is 00h and `tm_load_o` is 0. Storage bytes hold no defined value until they are written.
- R2: `rdata_o` shows, in the same cycle and without a clock, the byte at the current pointer. Addresses 0 to 6 return snapshot bytes. Snapshot byte i is taken from `live_time_i[8*i+7:8*i]`, in the order seconds, minutes, hours, day, date, month/century, year.
- R3: While no start, no stop and no pointer wrap occur, the snapshot stays unchanged even though `live_time_i` changes.
- R4: A clock edge with `start_i` or `stop_i` high copies `live_time_i`, masked as in R10, into the snapshot. The new values can be read from the next cycle.
- R5: A clock edge with `rd_i` or `wr_i` high, and `ptr_load_i` low, adds 1 to the pointer. When the pointer goes from 1Fh to 00h, the snapshot is reloaded at that same edge.
- R6: `ptr_load_i` sets the pointer to `ptr_val_i` and takes precedence over the increment. Loading 00h does not reload the snapshot.
- R7: A write at an address from 00h to 06h raises `tm_load_o` for exactly the next cycle. In that cycle `tm_addr_o` holds the address and `tm_data_o` holds the masked write data. The snapshot is not changed.
- R8: A write at an address from 10h to 1Fh stores all 8 bits. A later read of that address returns the stored byte.
- R9: Addresses 07h to 0Fh read as 00h. A write there changes no readable byte and does not raise `tm_load_o`.
- R10: Unused bits read as 0. The kept-bit masks are 7Fh for seconds, minutes and hours, 07h for day, 3Fh for date, 9Fh for month/century and FFh for year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bus start strobe |
| stop_i | input | 1 | Bus stop strobe |
| ptr_load_i | input | 1 | Load the pointer from `ptr_val_i` |
| ptr_val_i | input | 5 | Pointer value to load |
| rd_i | input | 1 | Byte-read strobe; consumes `rdata_o` |
| wr_i | input | 1 | Byte-write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Byte at the current pointer |
| live_time_i | input | 56 | Live counter bytes; byte i belongs to address i |
| tm_load_o | output | 1 | One-cycle load strobe to the counter |
| tm_addr_o | output | 3 | Index of the time byte being loaded |
| tm_data_o | output | 8 | Masked data for the counter |

## Verification
A snapshot that reloads when it should not, or misses a reload, first shows up at `rdata_o`. The error appears on the first read of a time byte after that edge, because the bench changes the live value on every cycle. A wrong pointer shows up in the very next cycle, since the read mux follows the pointer directly. A misrouted write shows up either as a wrong or missing `tm_load_o` in the following cycle, or as bad storage data when that address is read back.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int unsigned DW = 8;

  function automatic logic [DW-1:0] byte_mask(int unsigned idx);
    case (idx)
      0, 1, 2: byte_mask = 8'h7F;
      3:       byte_mask = 8'h07;
      4:       byte_mask = 8'h3F;
      5:       byte_mask = 8'h9F;
      default: byte_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_snap_ptr.sv
module rtc_snap_ptr #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] PtrMax = '1;

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o  = ptr_q;
  assign wrap_o = step_i && !load_i && (ptr_q == PtrMax);

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (ptr_q == $past(ptr_q) + 1'b1));
  assert_ptr_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_q == $past(load_val_i)));
  assert_ptr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(ptr_q));
endmodule

// File: rtl/rtc_snap_shadow.sv
module rtc_snap_shadow
  import rtc_snap_pkg::*;
#(
  parameter int unsigned NB = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                snap_i,
  input  logic [NB*DW-1:0]    live_i,
  output logic [NB-1:0][DW-1:0] shadow_o
);
  logic [NB-1:0][DW-1:0] shadow_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [DW-1:0] Mask = byte_mask(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     shadow_q[b] <= '0;
      else if (snap_i) shadow_q[b] <= live_i[b*DW +: DW] & Mask;
    end
  end

  assign shadow_o = shadow_q;

  assert_shadow_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(shadow_q));
  assert_shadow_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (shadow_q[0] == ($past(live_i[DW-1:0]) & 8'h7F)));
endmodule

// File: rtl/rtc_snap_ram.sv
module rtc_snap_ram
  import rtc_snap_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned RAW  = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rtc_snap_window.sv
module rtc_snap_window
  import rtc_snap_pkg::*;
#(
  parameter int unsigned AW         = 5,
  parameter int unsigned TIME_BYTES = 7,
  parameter int unsigned RAM_BASE   = 16,
  parameter int unsigned RAM_DEPTH  = 16,
  localparam int unsigned TIW       = $clog2(TIME_BYTES),
  localparam int unsigned RAW       = $clog2(RAM_DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       ptr_load_i,
  input  logic [AW-1:0]              ptr_val_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  input  logic [TIME_BYTES*DW-1:0]   live_time_i,
  output logic                       tm_load_o,
  output logic [TIW-1:0]             tm_addr_o,
  output logic [DW-1:0]              tm_data_o
);
  localparam logic [AW-1:0] TimeEnd = AW'(TIME_BYTES);
  localparam logic [AW-1:0] RamLo   = AW'(RAM_BASE);

  logic [AW-1:0]                  ptr;
  logic                           wrap;
  logic                           snap;
  logic [TIME_BYTES-1:0][DW-1:0]  shadow;
  logic [DW-1:0]                  ram_rdata;
  logic                           in_time, in_ram;
  logic                           ram_we;
  logic [TIW-1:0]                 tidx;
  logic [DW-1:0]                  wmask;

  rtc_snap_ptr #(.AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load_i),
    .load_val_i (ptr_val_i),
    .step_i     (rd_i | wr_i),
    .ptr_o      (ptr),
    .wrap_o     (wrap)
  );

  assign snap = start_i | stop_i | wrap;

  rtc_snap_shadow #(.NB(TIME_BYTES)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .snap_i   (snap),
    .live_i   (live_time_i),
    .shadow_o (shadow)
  );

  assign in_time = ptr < TimeEnd;
  assign in_ram  = ptr >= RamLo;
  assign ram_we  = wr_i & in_ram;
  assign tidx    = ptr[TIW-1:0];

  rtc_snap_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (ptr[RAW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  always_comb begin
    if (in_time)     rdata_o = shadow[tidx];
    else if (in_ram) rdata_o = ram_rdata;
    else             rdata_o = '0;
  end

  always_comb begin
    wmask = 8'hFF;
    for (int i = 0; i < TIME_BYTES; i++) begin
      if (int'(tidx) == i) wmask = byte_mask(i);
    end
  end

  // time writes bypass the snapshot and go to the live counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_load_o <= 1'b0;
      tm_addr_o <= '0;
      tm_data_o <= '0;
    end else begin
      tm_load_o <= wr_i & in_time;
      if (wr_i & in_time) begin
        tm_addr_o <= tidx;
        tm_data_o <= wdata_i & wmask;
      end
    end
  end

  assert_tm_addr_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tm_load_o |-> (int'(tm_addr_o) < TIME_BYTES));
  assert_tm_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_time) |=> tm_load_o);
  assert_no_load_outside_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && in_time) |=> !tm_load_o);
  assert_gap_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_time && !in_ram) |-> (rdata_o == '0));
  assert_wrap_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (ptr == '0) && (shadow[TIME_BYTES-1] == $past(live_time_i[TIME_BYTES*DW-1 -: DW])));
  assert_day_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr == AW'(3)) |-> (rdata_o[7:3] == '0));
endmodule

// File: tb/rtc_snap_window_tb.sv
module rtc_snap_window_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0, stop = 0, pload = 0, rd = 0, wr = 0;
  logic [4:0]  pval = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [55:0] live = 56'h0;
  logic        tm_load;
  logic [2:0]  tm_addr;
  logic [7:0]  tm_data;

  always #2.5 clk = ~clk;

  rtc_snap_window u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .ptr_load_i(pload), .ptr_val_i(pval), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .live_time_i(live),
    .tm_load_o(tm_load), .tm_addr_o(tm_addr), .tm_data_o(tm_data)
  );

  int n_vec = 0, n_bad = 0;
  int m_ptr;
  logic [7:0] m_sh [7];
  logic [7:0] m_ram [16];
  bit         m_ram_ok [16];
  logic       m_ld;
  logic [2:0] m_la;
  logic [7:0] m_ldd;

  function automatic logic [7:0] mask_of(int i);
    case (i)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [7:0] e;
    bit known = 1;
    if (m_ptr < 7) e = m_sh[m_ptr];
    else if (m_ptr >= 16) begin e = m_ram[m_ptr-16]; known = m_ram_ok[m_ptr-16]; end
    else e = 8'h00;
    if (known) cmp(tag, "rdata", 32'(rdata), 32'(e));
    cmp(tag, "tm_load", 32'(tm_load), 32'(m_ld));
    if (m_ld) begin
      cmp(tag, "tm_addr", 32'(tm_addr), 32'(m_la));
      cmp(tag, "tm_data", 32'(tm_data), 32'(m_ldd));
    end
  endtask

  task automatic cyc(string tag, bit st, bit sp, bit pl, int pv, bit r, bit w, logic [7:0] wd);
    bit wrapped;
    check_all(tag);
    start = st; stop = sp; pload = pl; pval = 5'(pv); rd = r; wr = w; wdata = wd;
    @(posedge clk);
    wrapped = (r | w) && !pl && (m_ptr == 31);
    m_ld = 0;
    if (w) begin
      if (m_ptr < 7) begin m_ld = 1; m_la = 3'(m_ptr); m_ldd = wd & mask_of(m_ptr); end
      else if (m_ptr >= 16) begin m_ram[m_ptr-16] = wd; m_ram_ok[m_ptr-16] = 1; end
    end
    if (st | sp | wrapped)
      for (int i = 0; i < 7; i++) m_sh[i] = live[8*i +: 8] & mask_of(i);
    if (pl) m_ptr = pv;
    else if (r | w) m_ptr = (m_ptr + 1) % 32;
    @(negedge clk);
    start = 0; stop = 0; pload = 0; rd = 0; wr = 0;
    live = {live[47:0], live[55:48]} ^ 56'h3C_5A_96_E1_27_B4_D8 ^ 56'(n_vec);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_ptr = 0; m_ld = 0; m_la = 0; m_ldd = 0;
    for (int i = 0; i < 7; i++) m_sh[i] = 8'h00;
    for (int i = 0; i < 16; i++) m_ram_ok[i] = 0;
    live = 56'hFF_EE_DD_CC_BB_AA_99;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    // R3 idle with live moving
    for (int i = 0; i < 5; i++) cyc("R3", 0, 0, 0, 0, 0, 0, 0);
    // R4 start reload, then R2 R10 read burst of time bytes
    cyc("R4", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R2_R10", 0, 0, 0, 0, 1, 0, 0);
    cyc("R4", 0, 1, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R3", 0, 0, 0, 0, 1, 0, 0);
    // R8 fill storage; the last write wraps (R5)
    cyc("R6", 0, 0, 1, 16, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc("R8_R5", 0, 0, 0, 0, 0, 1, 8'(8'hA5 ^ (i * 37)));
    for (int i = 0; i < 7; i++) cyc("R5", 0, 0, 0, 0, 1, 0, 0);
    // R9 gap writes ignored
    cyc("R6", 0, 0, 1, 7, 0, 0, 0);
    for (int i = 0; i < 9; i++) cyc("R9", 0, 0, 0, 0, 0, 1, 8'hFF);
    cyc("R6", 0, 0, 1, 7, 0, 0, 0);
    for (int i = 0; i < 9; i++) cyc("R9", 0, 0, 0, 0, 1, 0, 0);
    // R7 time writes forwarded, snapshot untouched
    cyc("R6", 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R7_R10", 0, 0, 0, 0, 0, 1, 8'hFF);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R7", 0, 0, 0, 0, 1, 0, 0);
    // R8 read back storage
    cyc("R6", 0, 0, 1, 16, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc("R8", 0, 0, 0, 0, 1, 0, 0);
    // R6 load wins over read in same cycle
    cyc("R6", 0, 0, 1, 20, 1, 0, 0);
    cyc("R6", 0, 0, 1, 31, 0, 1, 8'h3C);
    // full burst read across the wrap, twice (R5)
    for (int i = 0; i < 64; i++) cyc("R5_R2", 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R3", 0, 0, 0, 0, 0, 0, 0);
    check_all("R3");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule